// File: doc/BRIEF.md
# Dithered PWM DAC channel

This block drives one single-bit pulse-width-modulated output whose average level, after external low-pass filtering, approximates an analog value. A plain 8-bit duty gives 256 levels. This block gets finer steps by dithering: a 16-bit mask chooses which periods of a 16-period sequence stretch their on time by one extra clock cycle. The average on time can therefore move in steps of one sixteenth of a clock cycle per period.

Software writes one packed control word. The duty sits in the upper field and the dither mask sits in the lower field. The block samples the word only on the last cycle of a sequence. A word that changes in the middle of a sequence therefore never produces a broken period. A full design uses several copies of this channel side by side.

Top module: `dither_pwm_dac`

## Requirements
- R1: Each PWM period lasts PERIOD (default 255) clock cycles. Within a period, the output is high while the in-period position (0 to PERIOD-1) is below the effective duty, and low for the rest of the period.
- R2: The duty is taken from `cfg_word[23:16]` and the dither mask from `cfg_word[15:0]` (default widths).
- R3: Period k of a sequence (k = 0 for the first period after the sequence boundary) is governed by mask bit k.
- R4: The effective duty is the duty plus one when the governing mask bit is 1, and the duty alone when it is 0. A duty of 255 gives an output that is high for the whole period, and so does a duty of 254 with its mask bit set.
- R5: The control word is sampled only on the final cycle of a 16-period sequence. A value present at any other time has no effect on the output.
- R6: While `rst_n` is low, the output is low and the period and sequence counters return to their start. The loaded duty and mask clear to zero, so the whole first sequence after reset is low.
- R7: A sequence is 16 periods long, and sequences follow each other without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 24 | Duty in the upper 8 bits, dither mask in the lower 16 bits |
| pwm_o | output | 1 | PWM output |

## Verification
On every cycle, the assertions check the following:
- the period counter wraps after 255 cycles, and the sequence counter wraps after 16 periods;
- the loaded settings change only at a sequence boundary, and then take exactly the sampled word;
- the output is low during reset;
- a full-scale duty holds the output high, and a zero duty with a clear mask bit holds it low.

Only the bench scenarios can show that the following are correct:
- the pulse position and length in each period, measured against each mask bit;
- the summed on time of whole sequences;
- that words written in the middle of a sequence are ignored;
- that a mid-run reset restarts alignment.

// File: rtl/dither_pwm_dac.sv
module dither_pwm_dac #(
  parameter int DUTY_W  = 8,
  parameter int SEQ_LEN = 16,
  parameter int PERIOD  = 255
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DUTY_W+SEQ_LEN-1:0] cfg_word,
  output logic                      pwm_o
);
  localparam int PH_W = $clog2(PERIOD);
  localparam int SL_W = $clog2(SEQ_LEN);
  localparam int EW   = DUTY_W + 1;

  logic [PH_W-1:0]    phase_q;
  logic [SL_W-1:0]    slot_q;
  logic [DUTY_W-1:0]  duty_q;
  logic [SEQ_LEN-1:0] mask_q;
  logic [EW-1:0]      eff;
  logic               end_period, end_seq;

  assign end_period = (phase_q == PH_W'(PERIOD - 1));
  assign end_seq    = end_period && (slot_q == SL_W'(SEQ_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
      duty_q  <= '0;
      mask_q  <= '0;
    end else begin
      phase_q <= end_period ? '0 : phase_q + 1'b1;
      if (end_period)
        slot_q <= end_seq ? '0 : slot_q + 1'b1;
      if (end_seq) begin
        duty_q <= cfg_word[DUTY_W+SEQ_LEN-1:SEQ_LEN];
        mask_q <= cfg_word[SEQ_LEN-1:0];
      end
    end
  end

  assign eff   = EW'(duty_q) + EW'(mask_q[slot_q]);
  assign pwm_o = EW'(phase_q) < eff;
endmodule

// File: rtl/dither_pwm_dac_checks.sv
module dither_pwm_dac_checks #(
  parameter int DUTY_W  = 8,
  parameter int SEQ_LEN = 16,
  parameter int PERIOD  = 255,
  parameter int PH_W    = 8,
  parameter int SL_W    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [DUTY_W+SEQ_LEN-1:0] cfg_word,
  input logic                      pwm_o,
  input logic [PH_W-1:0]           phase_q,
  input logic [SL_W-1:0]           slot_q,
  input logic [DUTY_W-1:0]         duty_q,
  input logic [SEQ_LEN-1:0]        mask_q
);
  logic last_ph, last_seq;
  assign last_ph  = (phase_q == PH_W'(PERIOD - 1));
  assign last_seq = last_ph && (slot_q == SL_W'(SEQ_LEN - 1));

  p_reset_low_r6: assert property (@(posedge clk) !rst_n |-> !pwm_o);

  p_period_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last_ph |=> phase_q == '0);

  p_seq_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_seq |=> slot_q == '0);

  p_hold_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !last_seq |=> $stable(duty_q) && $stable(mask_q));

  p_load_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_seq |=> duty_q == $past(cfg_word[DUTY_W+SEQ_LEN-1:SEQ_LEN])
              && mask_q == $past(cfg_word[SEQ_LEN-1:0]));

  p_full_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == {DUTY_W{1'b1}}) |-> pwm_o);

  p_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0 && !mask_q[slot_q]) |-> !pwm_o);
endmodule

bind dither_pwm_dac dither_pwm_dac_checks #(
  .DUTY_W(DUTY_W), .SEQ_LEN(SEQ_LEN), .PERIOD(PERIOD), .PH_W(PH_W), .SL_W(SL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .pwm_o(pwm_o),
  .phase_q(phase_q), .slot_q(slot_q), .duty_q(duty_q), .mask_q(mask_q)
);

// File: tb/sim_dither_pwm_dac.sv
module sim_dither_pwm_dac;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [23:0] VEC_CFG [NV] = '{
    24'h00_0000, 24'h00_0001, 24'h80_8001, 24'hFF_FFFF,
    24'hFE_FFFF, 24'h10_A5C3, 24'hFF_0000, 24'h01_0000};
  localparam int VEC_SUM [NV] = '{0, 1, 2050, 4080, 4080, 264, 4080, 16};

  logic clk = 0, rst_n = 0, done = 0;
  logic [23:0] cfg_word = '0;
  logic pwm_o;
  int checks = 0, errors = 0;

  dither_pwm_dac u0 (.clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .pwm_o(pwm_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts and ends at a negedge with the block at the beginning of a sequence.
  task automatic run_seq(input logic [23:0] cur, input logic [23:0] nxt, input int exp_sum);
    int total = 0;
    for (int k = 0; k < 16; k++) begin
      int eff = int'(cur[23:16]) + int'(cur[k]);
      int exp_hi = (eff > 255) ? 255 : eff;
      int hi = 0, mis = 0;
      for (int p = 0; p < 255; p++) begin
        if (pwm_o) hi++;
        if (pwm_o !== (p < eff)) mis++;
        if (k == 8 && p == 0) cfg_word = nxt ^ 24'h5A_A55A;   // R5 ignored mid-sequence
        if (k == 15 && p == 200) cfg_word = nxt;
        @(negedge clk);
      end
      total += hi;
      check(hi == exp_hi, "R3,R4 on-cycles in period", hi, exp_hi);
      check(mis == 0, "R1 pulse position mismatches", mis, 0);
    end
    check(total == exp_sum, "R2,R7 sequence on-cycle sum", total, exp_sum);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_word = 24'hFF_FFFF;
    repeat (3) @(negedge clk);
    check(pwm_o == 1'b0, "R6 output low in reset", int'(pwm_o), 0);
    rst_n = 1;
    cfg_word = VEC_CFG[0];
    run_seq(24'h0, VEC_CFG[0], 0);  // R6 first sequence after reset is low
    for (int i = 0; i < NV; i++)
      run_seq(VEC_CFG[i], VEC_CFG[(i + 1 < NV) ? i + 1 : i], VEC_SUM[i]);

    // Directed: reset in the middle of a sequence with a full-scale word present
    cfg_word = 24'hFF_FFFF;
    repeat (1000) @(negedge clk);
    rst_n = 0;
    repeat (3) begin
      @(negedge clk);
      check(pwm_o == 1'b0, "R6 output low in mid-run reset", int'(pwm_o), 0);
    end
    rst_n = 1;
    cfg_word = 24'h03_0000;
    run_seq(24'h0, 24'h03_0000, 0);              // R6 loaded word cleared
    run_seq(24'h03_0000, 24'h00_8000, 48);       // R1 alignment restarted
    run_seq(24'h00_8000, 24'h00_8000, 1);        // R3 only last period
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule